// File: doc/BRIEF.md
# BCD Clock-Calendar Register Bank

This block is the timekeeping register set of a battery-backed clock chip. It occupies the eight highest byte addresses of a byte-wide address space: a control byte, then seconds, minutes, hours, weekday/century, date, month and year. Every time field is read and written in packed BCD. A one-cycle pulse on the 1 Hz tick input advances the time by one second. The seconds carry into the minutes, the minutes into the hours, the hours into the date and the weekday, the date into the month and the month into the year. Month length follows the calendar, and February has 29 days in leap years.

Software changes one field per write strobe. A value that is out of range or is not valid BCD is dropped without any sign, and the field keeps its old contents. The top bit of the seconds byte is a stop flag. While the stop flag is set the clock holds. Clearing the flag lets counting go on from the held time. The year register holds a two-digit offset from a base year that is a parameter, and leap years are found from the base year plus that offset.

A read strobe returns the addressed byte on the read-data port one cycle later. Addresses outside the eight-byte bank read as all ones and ignore writes.

Top module: `bcd_rtc_regs`

## Requirements
- R1: The bank is decoded when the upper address bits are all ones. The low three address bits select the register: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday/century, 5 date, 6 month, 7 year. Read data is registered and appears on the cycle after the read strobe. A read outside the bank returns 0xFF, and a write outside the bank changes no register.
- R2: After reset the bank reads control 0x90, seconds 0x00, minutes 0x00, hours 0x00, weekday/century 0x01, date 0x01, month 0x01 and year 0x00, with the stop flag clear.
- R3: A control write stores the write data ANDed with 0x5F and then ORed with 0x90.
- R4: A seconds write always loads the stop flag from bit 7. The seconds value in bits 6:0 is loaded only if it is valid BCD in the range 00–59. A seconds read returns the stop flag in bit 7 and the BCD seconds below it.
- R5: A minutes write loads bits 6:0 only if they are valid BCD in 00–59. An hours write loads bits 5:0 only if they are valid BCD in 00–23. The discarded upper bits read back as 0.
- R6: A weekday/century write stores bits 2:0 as the weekday and bit 6 as the century flag. The register reads back as {0, century, 000, weekday}.
- R7: A date write loads bits 5:0 only if they are valid BCD in 01–31.
- R8: A month write loads bits 4:0 only if they are valid BCD in 01–12.
- R9: A year write loads all eight bits only if they are valid BCD (00–99).
- R10: While the stop flag is set, ticks change no time field. Clearing the flag by a seconds write with an invalid value keeps the held seconds, and the next tick counts on from them.
- R11: Each tick advances the seconds. 59 seconds wraps to 00 and adds one minute, and 59 minutes wraps to 00 and adds one hour. A field written in the same cycle as a tick takes the written value.
- R12: When the hours wrap from 23, the date advances. The date wraps to 01 after the last day of the month (30 or 31 days, February 28, or 29 in a leap year), and this advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00. The leap-year test uses the Gregorian rule on BASE_YEAR plus the year.
- R13: At each midnight the weekday advances by one, and weekday 7 wraps to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| addr | input | ADDR_W | Byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, valid the cycle after rd_en |

## Verification
Two assumptions sit under the assertions. First, only a seconds write changes the stop flag. Second, the checks on holding and carrying leave out any cycle in which a write strobe is active, because a write may override the field under test. The stimulus therefore keeps tick pulses and write strobes in separate cycles. Each tick is one cycle long, and each register access is one strobe cycle driven between clock edges, so every carry and hold the assertions watch happens in a cycle with no write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [5:0] sec;
    logic [5:0] min;
    logic [4:0] hr;
    logic [2:0] wday;
    logic [4:0] date;
    logic [3:0] mon;
    logic [6:0] yr;
  } cal_t;

  typedef struct packed {
    logic ctrl;
    logic stop;
    logic sec;
    logic min;
    logic hr;
    logic day;
    logic date;
    logic mon;
    logic yr;
  } ld_t;

  localparam logic [2:0] OFF_CTRL = 3'd0;
  localparam logic [2:0] OFF_SEC  = 3'd1;
  localparam logic [2:0] OFF_MIN  = 3'd2;
  localparam logic [2:0] OFF_HR   = 3'd3;
  localparam logic [2:0] OFF_DAY  = 3'd4;
  localparam logic [2:0] OFF_DATE = 3'd5;
  localparam logic [2:0] OFF_MON  = 3'd6;
  localparam logic [2:0] OFF_YR   = 3'd7;

  localparam logic [7:0] CTRL_KEEP  = 8'h5F;
  localparam logic [7:0] CTRL_FORCE = 8'h90;

  function automatic logic bcd_ok(input logic [7:0] v);
    return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic [7:0] bcd2bin(input logic [7:0] v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] b);
    return {4'(b / 7'd10), 4'(b % 7'd10)};
  endfunction

  function automatic logic is_leap(input int unsigned y);
    return (((y % 4) == 0) && ((y % 100) != 0)) || ((y % 400) == 0);
  endfunction

  function automatic logic [4:0] days_in_month(input logic [3:0] m, input logic leap);
    case (m)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_wr_decode.sv
module rtc_wr_decode
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output ld_t               ld,
  output cal_t              val,
  output logic [7:0]        ctrl_val,
  output logic              stop_val,
  output logic              cen_val
);

  localparam int HI_W = ADDR_W - 3;

  logic       hit;
  logic [2:0] off;
  logic [7:0] sec_f, min_f, hr_f, date_f, mon_f;
  logic [7:0] sec_b, min_b, hr_b, date_b, mon_b, yr_b;
  logic       sec_ok, min_ok, hr_ok, date_ok, mon_ok, yr_ok;

  assign hit = wr_en && (addr[ADDR_W-1:3] == {HI_W{1'b1}});
  assign off = addr[2:0];

  // fields masked to the bits each register accepts
  assign sec_f  = {1'b0, wr_data[6:0]};
  assign min_f  = {1'b0, wr_data[6:0]};
  assign hr_f   = {2'b0, wr_data[5:0]};
  assign date_f = {2'b0, wr_data[5:0]};
  assign mon_f  = {3'b0, wr_data[4:0]};

  assign sec_b  = bcd2bin(sec_f);
  assign min_b  = bcd2bin(min_f);
  assign hr_b   = bcd2bin(hr_f);
  assign date_b = bcd2bin(date_f);
  assign mon_b  = bcd2bin(mon_f);
  assign yr_b   = bcd2bin(wr_data);

  assign sec_ok  = bcd_ok(sec_f)  && (sec_b <= 8'd59);
  assign min_ok  = bcd_ok(min_f)  && (min_b <= 8'd59);
  assign hr_ok   = bcd_ok(hr_f)   && (hr_b  <= 8'd23);
  assign date_ok = bcd_ok(date_f) && (date_b != 8'd0) && (date_b <= 8'd31);
  assign mon_ok  = bcd_ok(mon_f)  && (mon_b  != 8'd0) && (mon_b  <= 8'd12);
  assign yr_ok   = bcd_ok(wr_data);

  always_comb begin
    ld.ctrl = hit && (off == OFF_CTRL);
    ld.stop = hit && (off == OFF_SEC);
    ld.sec  = hit && (off == OFF_SEC)  && sec_ok;
    ld.min  = hit && (off == OFF_MIN)  && min_ok;
    ld.hr   = hit && (off == OFF_HR)   && hr_ok;
    ld.day  = hit && (off == OFF_DAY);
    ld.date = hit && (off == OFF_DATE) && date_ok;
    ld.mon  = hit && (off == OFF_MON)  && mon_ok;
    ld.yr   = hit && (off == OFF_YR)   && yr_ok;
  end

  always_comb begin
    val.sec  = sec_b[5:0];
    val.min  = min_b[5:0];
    val.hr   = hr_b[4:0];
    val.wday = wr_data[2:0];
    val.date = date_b[4:0];
    val.mon  = mon_b[3:0];
    val.yr   = yr_b[6:0];
  end

  assign ctrl_val = (wr_data & CTRL_KEEP) | CTRL_FORCE;
  assign stop_val = wr_data[7];
  assign cen_val  = wr_data[6];

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  ld_t        ld,
  input  cal_t       val,
  input  logic [7:0] ctrl_val,
  input  logic       stop_val,
  input  logic       cen_val,
  output cal_t       cal_q,
  output logic [7:0] ctrl_q,
  output logic       stop_q,
  output logic       cen_q,
  output logic       advance,
  output logic       sec_wrap,
  output logic       min_wrap,
  output logic       hr_wrap,
  output logic       date_wrap,
  output logic       mon_wrap
);

  localparam cal_t CAL_RST = '{sec: 6'd0, min: 6'd0, hr: 5'd0, wday: 3'd1,
                               date: 5'd1, mon: 4'd1, yr: 7'd0};

  logic       leap;
  logic [4:0] dim;
  cal_t       nxt;

  assign leap = is_leap(32'(BASE_YEAR) + 32'(cal_q.yr));
  assign dim  = days_in_month(cal_q.mon, leap);

  // carry chain, one named event per stage
  assign advance   = tick && !stop_q;
  assign sec_wrap  = advance   && (cal_q.sec  >= 6'd59);
  assign min_wrap  = sec_wrap  && (cal_q.min  >= 6'd59);
  assign hr_wrap   = min_wrap  && (cal_q.hr   >= 5'd23);
  assign date_wrap = hr_wrap   && (cal_q.date >= dim);
  assign mon_wrap  = date_wrap && (cal_q.mon  >= 4'd12);

  always_comb begin
    nxt = cal_q;
    if (advance)
      nxt.sec = sec_wrap ? 6'd0 : cal_q.sec + 6'd1;
    if (sec_wrap)
      nxt.min = min_wrap ? 6'd0 : cal_q.min + 6'd1;
    if (min_wrap)
      nxt.hr = hr_wrap ? 5'd0 : cal_q.hr + 5'd1;
    if (hr_wrap) begin
      nxt.wday = (cal_q.wday >= 3'd7) ? 3'd1 : cal_q.wday + 3'd1;
      nxt.date = date_wrap ? 5'd1 : cal_q.date + 5'd1;
    end
    if (date_wrap)
      nxt.mon = mon_wrap ? 4'd1 : cal_q.mon + 4'd1;
    if (mon_wrap)
      nxt.yr = (cal_q.yr >= 7'd99) ? 7'd0 : cal_q.yr + 7'd1;
    // a write wins over the tick for the field it addresses
    if (ld.sec)  nxt.sec  = val.sec;
    if (ld.min)  nxt.min  = val.min;
    if (ld.hr)   nxt.hr   = val.hr;
    if (ld.day)  nxt.wday = val.wday;
    if (ld.date) nxt.date = val.date;
    if (ld.mon)  nxt.mon  = val.mon;
    if (ld.yr)   nxt.yr   = val.yr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= CAL_RST;
      ctrl_q <= CTRL_FORCE;
      stop_q <= 1'b0;
      cen_q  <= 1'b0;
    end else begin
      cal_q <= nxt;
      if (ld.ctrl) ctrl_q <= ctrl_val;
      if (ld.stop) stop_q <= stop_val;
      if (ld.day)  cen_q  <= cen_val;
    end
  end

endmodule

// File: rtl/rtc_rd_mux.sv
module rtc_rd_mux
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  cal_t              cal,
  input  logic [7:0]        ctrl,
  input  logic              stop,
  input  logic              cen,
  output logic [7:0]        rd_data
);

  localparam int HI_W = ADDR_W - 3;

  logic       hit;
  logic [7:0] sel;

  assign hit = addr[ADDR_W-1:3] == {HI_W{1'b1}};

  always_comb begin
    sel = 8'hFF;
    if (hit) begin
      case (addr[2:0])
        OFF_CTRL: sel = ctrl;
        OFF_SEC:  sel = {stop, 7'(bin2bcd({1'b0, cal.sec}))};
        OFF_MIN:  sel = bin2bcd({1'b0, cal.min});
        OFF_HR:   sel = bin2bcd({2'b0, cal.hr});
        OFF_DAY:  sel = {1'b0, cen, 3'b000, cal.wday};
        OFF_DATE: sel = bin2bcd({2'b0, cal.date});
        OFF_MON:  sel = bin2bcd({3'b0, cal.mon});
        default:  sel = bin2bcd(cal.yr);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= sel;
  end

endmodule

// File: rtl/bcd_rtc_regs.sv
module bcd_rtc_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BASE_YEAR = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);

  ld_t        ld;
  cal_t       wr_val;
  logic [7:0] ctrl_val;
  logic       stop_val, cen_val;

  cal_t       cal_q;
  logic [7:0] ctrl_q;
  logic       stop_q, cen_q;
  logic       advance, sec_wrap, min_wrap, hr_wrap, date_wrap, mon_wrap;

  // field views for the checker
  logic [5:0] sec_q, min_q;
  logic [4:0] hr_q, date_q;
  logic [2:0] wday_q;
  logic [3:0] mon_q;

  assign sec_q  = cal_q.sec;
  assign min_q  = cal_q.min;
  assign hr_q   = cal_q.hr;
  assign wday_q = cal_q.wday;
  assign date_q = cal_q.date;
  assign mon_q  = cal_q.mon;

  rtc_wr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ld       (ld),
    .val      (wr_val),
    .ctrl_val (ctrl_val),
    .stop_val (stop_val),
    .cen_val  (cen_val)
  );

  rtc_calendar #(.BASE_YEAR(BASE_YEAR)) u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_1hz),
    .ld        (ld),
    .val       (wr_val),
    .ctrl_val  (ctrl_val),
    .stop_val  (stop_val),
    .cen_val   (cen_val),
    .cal_q     (cal_q),
    .ctrl_q    (ctrl_q),
    .stop_q    (stop_q),
    .cen_q     (cen_q),
    .advance   (advance),
    .sec_wrap  (sec_wrap),
    .min_wrap  (min_wrap),
    .hr_wrap   (hr_wrap),
    .date_wrap (date_wrap),
    .mon_wrap  (mon_wrap)
  );

  rtc_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .cal     (cal_q),
    .ctrl    (ctrl_q),
    .stop    (stop_q),
    .cen     (cen_q),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       advance,
  input logic       stop_q,
  input logic [7:0] ctrl_q,
  input logic [5:0] sec_q,
  input logic [5:0] min_q,
  input logic [4:0] hr_q,
  input logic [2:0] wday_q,
  input logic [4:0] date_q,
  input logic [3:0] mon_q
);

  a_r3_ctrl_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] && ctrl_q[4] && !ctrl_q[5]);

  a_r4_sec_range: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q <= 6'd59);

  a_r5_min_hr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (min_q <= 6'd59) && (hr_q <= 5'd23));

  a_r8_date_month_range: assert property (@(posedge clk) disable iff (!rst_n)
    (date_q != 5'd0) && (mon_q != 4'd0) && (mon_q <= 4'd12));

  a_r10_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)
                            && $stable(date_q) && $stable(mon_q)));

  a_r11_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sec_q == 6'd59 && !wr_en) |=> (sec_q == 6'd0) && (min_q != $past(min_q)));

  a_r13_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && sec_q == 6'd59 && min_q == 6'd59 && hr_q == 5'd23
     && wday_q == 3'd7 && !wr_en) |=> (wday_q == 3'd1));

endmodule

bind bcd_rtc_regs rtc_regs_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .advance (advance),
  .stop_q  (stop_q),
  .ctrl_q  (ctrl_q),
  .sec_q   (sec_q),
  .min_q   (min_q),
  .hr_q    (hr_q),
  .wday_q  (wday_q),
  .date_q  (date_q),
  .mon_q   (mon_q)
);

// File: tb/bcd_rtc_regs_tb.sv
module bcd_rtc_regs_tb;

  localparam int ADDR_W = 13;
  localparam logic [ADDR_W-1:0] BANK = {{(ADDR_W-3){1'b1}}, 3'b000};
  localparam int NV = 27;

  // {offset, write data, expected readback}; R3..R9 and R4 stop flag
  localparam logic [23:0] VEC [NV] = '{
    {8'd0, 8'hFF, 8'hDF}, {8'd0, 8'h00, 8'h90},                        // R3
    {8'd1, 8'h45, 8'h45}, {8'd1, 8'h60, 8'h45}, {8'd1, 8'h3A, 8'h45},  // R4
    {8'd2, 8'h59, 8'h59}, {8'd2, 8'hDA, 8'h59}, {8'd2, 8'h92, 8'h12},  // R5
    {8'd3, 8'h23, 8'h23}, {8'd3, 8'h24, 8'h23}, {8'd3, 8'hC7, 8'h07},  // R5
    {8'd4, 8'hFF, 8'h47}, {8'd4, 8'h03, 8'h03},                        // R6
    {8'd5, 8'h00, 8'h01}, {8'd5, 8'h31, 8'h31}, {8'd5, 8'h32, 8'h31},
    {8'd5, 8'hC9, 8'h09},                                              // R7
    {8'd6, 8'h00, 8'h01}, {8'd6, 8'h13, 8'h01}, {8'd6, 8'h12, 8'h12},
    {8'd6, 8'hE5, 8'h05},                                              // R8
    {8'd7, 8'h99, 8'h99}, {8'd7, 8'hA0, 8'h99}, {8'd7, 8'h07, 8'h07},  // R9
    {8'd1, 8'h80, 8'h80}, {8'd1, 8'hE5, 8'h80}, {8'd1, 8'h10, 8'h10}   // R4
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_1hz = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [7:0]        wr_data = 8'h00;
  logic              rd_en = 1'b0;
  logic [7:0]        rd_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bcd_rtc_regs #(.ADDR_W(ADDR_W), .BASE_YEAR(2000)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_abs(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] off, input logic [7:0] d);
    wr_abs(BANK | ADDR_W'(off), d);
  endtask

  task automatic rd_abs(input logic [ADDR_W-1:0] a, output logic [7:0] q);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic rd_chk(input logic [2:0] off, input logic [7:0] exp, input string tag);
    logic [7:0] q;
    rd_abs(BANK | ADDR_W'(off), q);
    chk(tag, q, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] y, m, d, h, mi, s);
    wr(3'd7, y); wr(3'd6, m); wr(3'd5, d);
    wr(3'd3, h); wr(3'd2, mi); wr(3'd1, s);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all R) actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset contents
    rd_chk(3'd0, 8'h90, "R2 ctrl");
    rd_chk(3'd1, 8'h00, "R2 sec");
    rd_chk(3'd2, 8'h00, "R2 min");
    rd_chk(3'd3, 8'h00, "R2 hr");
    rd_chk(3'd4, 8'h01, "R2 day");
    rd_chk(3'd5, 8'h01, "R2 date");
    rd_chk(3'd6, 8'h01, "R2 month");
    rd_chk(3'd7, 8'h00, "R2 year");

    // vector table: write then read back
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd_chk(VEC[i][18:16], VEC[i][7:0], $sformatf("R3-9 vec%0d", i));
    end

    // R1 out-of-bank accesses
    rd_abs('0, q);
    chk("R1 outside read", q, 8'hFF);
    wr(3'd7, 8'h42);
    wr_abs(BANK - 1, 8'h11);
    rd_chk(3'd7, 8'h42, "R1 outside write ignored");

    // R11 second and minute carry
    set_time(8'h05, 8'h06, 8'h07, 8'h10, 8'h10, 8'h59);
    tick();
    rd_chk(3'd1, 8'h00, "R11 sec wrap");
    rd_chk(3'd2, 8'h11, "R11 min carry");
    tick();
    rd_chk(3'd1, 8'h01, "R11 sec inc");

    // R12 R13 full year rollover
    wr(3'd4, 8'h07);
    set_time(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk(3'd1, 8'h00, "R12 sec");
    rd_chk(3'd2, 8'h00, "R12 min");
    rd_chk(3'd3, 8'h00, "R12 hr");
    rd_chk(3'd5, 8'h01, "R12 date");
    rd_chk(3'd6, 8'h01, "R12 month");
    rd_chk(3'd7, 8'h00, "R12 year");
    rd_chk(3'd4, 8'h01, "R13 weekday wrap");

    // R12 leap year 2024
    set_time(8'h24, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk(3'd5, 8'h29, "R12 leap date");
    rd_chk(3'd6, 8'h02, "R12 leap month");
    wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
    tick();
    rd_chk(3'd5, 8'h01, "R12 leap end date");
    rd_chk(3'd6, 8'h03, "R12 leap end month");

    // R12 common year 2023
    set_time(8'h23, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk(3'd5, 8'h01, "R12 common date");
    rd_chk(3'd6, 8'h03, "R12 common month");

    // R12 year 2000 is leap (400 rule)
    set_time(8'h00, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk(3'd5, 8'h29, "R12 y2000 leap");

    // R12 thirty-day month
    set_time(8'h10, 8'h04, 8'h30, 8'h23, 8'h59, 8'h59);
    tick();
    rd_chk(3'd5, 8'h01, "R12 april date");
    rd_chk(3'd6, 8'h05, "R12 april month");

    // R13 weekday plain advance
    wr(3'd4, 8'h43);
    wr(3'd3, 8'h23); wr(3'd2, 8'h59); wr(3'd1, 8'h59);
    tick();
    rd_chk(3'd4, 8'h44, "R13 weekday inc");

    // R10 stop and resume
    wr(3'd2, 8'h20);
    wr(3'd1, 8'hB0);
    tick(); tick(); tick();
    rd_chk(3'd1, 8'hB0, "R10 frozen sec");
    rd_chk(3'd2, 8'h20, "R10 frozen min");
    wr(3'd1, 8'h7F);
    rd_chk(3'd1, 8'h30, "R10 resume held");
    tick();
    rd_chk(3'd1, 8'h31, "R10 resume count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule